// File: doc/BRIEF.md
# Bridge Target Write Terminator

This block sits behind the target side of a two-bus bridge and decides, one data phase at a time, how an incoming write is answered. It is told what kind of write is running: a delayed write, a posted memory write, or a posted memory write and invalidate. It also sees the current DWORD address, the programmed cache line size, and a configuration bit that picks line-based or page-based breaking of posted writes. Finally it sees the room left in the posted write data FIFO and in the delayed transaction queue. From these it answers each phase with accept, disconnect (data taken, transfer ends here) or retry (nothing taken).

Accepted data is handed on through a one-word push port. A write that directly follows another without an idle bus cycle is refused when the fast back-to-back enable for its direction is cleared. The direction is upstream or downstream, and each has its own enable. Bus pin sequencing, forwarding to the far bus, ordering and reads are handled elsewhere.

Top module: `bwr_term`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `rsp` is 2'b00 (idle) and `push_vld` is 0. Response codes: 2'b00 idle, 2'b01 accept, 2'b10 retry, 2'b11 disconnect. Accept and disconnect both take the data; retry takes none.
- R2: A delayed write phase (`ph_kind` 2'b00) with `dtq_free` nonzero is answered with disconnect, so every delayed write moves exactly one DWORD.
- R3: A delayed write phase with `dtq_free` zero is answered with retry and pushes nothing. A phase with the unused kind code 2'b11 is also answered with retry.
- R4: A posted phase (`ph_kind` 2'b01 memory write, 2'b10 memory write and invalidate) with `fifo_free` zero is answered with retry and pushes nothing.
- R5: A posted phase with `fifo_free` equal to 1 is answered with disconnect, since its word fills the FIFO.
- R6: A posted memory write with `cfg_disc_cl` 0 is disconnected on the phase whose following DWORD address has its low 10 bits all zero (a 4KB boundary), and accepted otherwise when room allows.
- R7: A posted memory write with `cfg_disc_cl` 1 and a cache line size of 1, 2, 4, 8 or 16 DWORDs is disconnected on the phase whose following DWORD address is a multiple of the line size.
- R8: When `cfg_cls` holds any other value, the line size is invalid and line-based disconnects of posted memory writes fall back to the 4KB boundary.
- R9: A memory write and invalidate is disconnected at every 4KB boundary. It is also disconnected at a valid line boundary when `fifo_free` minus one (the room left after this word) is smaller than the line size.
- R10: On the first phase of a write marked fast back-to-back (`ph_fbb` 1), the answer is retry unless the enable for its direction is set. For upstream (`ph_up` 1) that enable is `cfg_fbb_cmd`; for downstream it is `cfg_fbb_brctl`. This check ranks above all others except the unused kind code.
- R11: The response and push appear on the clock edge after the edge that samples the phase, and `push_data` equals the `ph_data` of that phase.
- R12: A cycle without `ph_valid` gives `rsp` 2'b00 and no push on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ph_valid | input | 1 | A write data phase is offered this cycle |
| ph_first | input | 1 | This phase is the first of its transaction |
| ph_fbb | input | 1 | Transaction follows the previous one fast back-to-back |
| ph_kind | input | 2 | Write kind code (see R2 to R4) |
| ph_up | input | 1 | 1 for upstream, 0 for downstream |
| ph_addr | input | AW (30) | DWORD address of this phase |
| ph_data | input | DW (32) | Write data of this phase |
| cfg_cls | input | 8 | Cache line size in DWORDs |
| cfg_disc_cl | input | 1 | 1 selects line boundaries for posted memory writes |
| cfg_fbb_cmd | input | 1 | Fast back-to-back enable, upstream |
| cfg_fbb_brctl | input | 1 | Fast back-to-back enable, downstream |
| fifo_free | input | FFW (6) | Free DWORDs in the posted write FIFO |
| dtq_free | input | QW (2) | Open delayed transaction queue entries |
| rsp | output | 2 | Registered response code |
| push_vld | output | 1 | Word pushed to the buffer this cycle |
| push_data | output | DW (32) | Pushed word |

## Verification
Every answer is registered once, so a phase presented before a rising edge shows its response, push strobe and pushed word after that edge and stays there for the whole following cycle. The bench changes inputs on falling edges and reads outputs on the next falling edge, half a cycle after the result is due. That includes the idle cycles used for R12 and the cycle straight after reset for R1. Directed phases hit the 4KB and line edges, the room-of-one and empty cases, and both fast back-to-back directions. Seeded random phases, weighted toward boundary addresses and small free counts, are compared against a bench function that derives the answer from the requirements.

// File: rtl/bwr_pkg.sv
package bwr_pkg;

    localparam int CLS_W    = 8;
    localparam int LINE_MAX = 16;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'b00,
        RSP_ACC   = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_DISC  = 2'b11
    } rsp_e;

    typedef enum logic [1:0] {
        K_DLY  = 2'b00,
        K_PMW  = 2'b01,
        K_MWI  = 2'b10,
        K_RSVD = 2'b11
    } kind_e;

    typedef struct packed {
        rsp_e rsp;
        logic take;
    } verdict_t;

    function automatic logic line_size_ok(input logic [CLS_W-1:0] c);
        return (c == CLS_W'(1)) || (c == CLS_W'(2)) || (c == CLS_W'(4)) ||
               (c == CLS_W'(8)) || (c == CLS_W'(LINE_MAX));
    endfunction

endpackage

// File: rtl/bwr_admit.sv
module bwr_admit
    import bwr_pkg::*;
#(
    parameter int FFW = 6,
    parameter int QW  = 2
) (
    input  kind_e          kind_i,
    input  logic           first_i,
    input  logic           fbb_i,
    input  logic           up_i,
    input  logic           en_cmd_i,
    input  logic           en_br_i,
    input  logic [FFW-1:0] fifo_free_i,
    input  logic [QW-1:0]  dtq_free_i,
    output logic           block_o,
    output logic           final_o
);
    logic fbb_allowed;
    logic no_room;

    always_comb begin
        fbb_allowed = up_i ? en_cmd_i : en_br_i;
        no_room     = (kind_i == K_DLY) ? (dtq_free_i == '0) : (fifo_free_i == '0);
        block_o     = (kind_i == K_RSVD) || (first_i && fbb_i && !fbb_allowed) || no_room;
        final_o     = (kind_i == K_DLY) || (fifo_free_i == FFW'(1));
    end

endmodule

// File: rtl/bwr_bound.sv
module bwr_bound
    import bwr_pkg::*;
#(
    parameter int AW       = 30,
    parameter int FFW      = 6,
    parameter int PAGE_LOG = 10
) (
    input  kind_e             kind_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [CLS_W-1:0]  cls_i,
    input  logic              line_mode_i,
    input  logic [FFW-1:0]    fifo_free_i,
    output logic              hit_o
);
    localparam int OFS_W = $clog2(LINE_MAX);
    localparam int CMP_W = (FFW > CLS_W) ? FFW : CLS_W;

    logic [AW-1:0]    next_addr;
    logic [OFS_W-1:0] line_mask;
    logic             page_hit, line_hit, cls_valid, short_room;

    always_comb begin
        next_addr  = addr_i + AW'(1);
        cls_valid  = line_size_ok(cls_i);
        line_mask  = cls_i[OFS_W-1:0] - OFS_W'(1);
        page_hit   = (next_addr[PAGE_LOG-1:0] == '0);
        line_hit   = cls_valid && ((next_addr[OFS_W-1:0] & line_mask) == '0);
        short_room = (CMP_W'(fifo_free_i) <= CMP_W'(cls_i));
        unique case (kind_i)
            K_PMW:   hit_o = (line_mode_i && cls_valid) ? line_hit : page_hit;
            K_MWI:   hit_o = page_hit || (line_hit && short_room);
            default: hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bwr_term.sv
module bwr_term
    import bwr_pkg::*;
#(
    parameter int AW       = 30,
    parameter int DW       = 32,
    parameter int FFW      = 6,
    parameter int QW       = 2,
    parameter int PAGE_LOG = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ph_valid,
    input  logic             ph_first,
    input  logic             ph_fbb,
    input  logic [1:0]       ph_kind,
    input  logic             ph_up,
    input  logic [AW-1:0]    ph_addr,
    input  logic [DW-1:0]    ph_data,
    input  logic [CLS_W-1:0] cfg_cls,
    input  logic             cfg_disc_cl,
    input  logic             cfg_fbb_cmd,
    input  logic             cfg_fbb_brctl,
    input  logic [FFW-1:0]   fifo_free,
    input  logic [QW-1:0]    dtq_free,
    output logic [1:0]       rsp,
    output logic             push_vld,
    output logic [DW-1:0]    push_data
);
    kind_e    kind;
    logic     blocked, room_last, at_bound;
    verdict_t verdict;
    rsp_e     rsp_q;

    assign kind = kind_e'(ph_kind);

    bwr_admit #(.FFW(FFW), .QW(QW)) u_admit (
        .kind_i      (kind),
        .first_i     (ph_first),
        .fbb_i       (ph_fbb),
        .up_i        (ph_up),
        .en_cmd_i    (cfg_fbb_cmd),
        .en_br_i     (cfg_fbb_brctl),
        .fifo_free_i (fifo_free),
        .dtq_free_i  (dtq_free),
        .block_o     (blocked),
        .final_o     (room_last)
    );

    bwr_bound #(.AW(AW), .FFW(FFW), .PAGE_LOG(PAGE_LOG)) u_bound (
        .kind_i      (kind),
        .addr_i      (ph_addr),
        .cls_i       (cfg_cls),
        .line_mode_i (cfg_disc_cl),
        .fifo_free_i (fifo_free),
        .hit_o       (at_bound)
    );

    always_comb begin
        if (blocked) begin
            verdict = '{rsp: RSP_RETRY, take: 1'b0};
        end else if (room_last || at_bound) begin
            verdict = '{rsp: RSP_DISC, take: 1'b1};
        end else begin
            verdict = '{rsp: RSP_ACC, take: 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_q     <= RSP_IDLE;
            push_vld  <= 1'b0;
            push_data <= '0;
        end else begin
            if (ph_valid) begin
                rsp_q    <= verdict.rsp;
                push_vld <= verdict.take;
            end else begin
                rsp_q    <= RSP_IDLE;
                push_vld <= 1'b0;
            end
            if (ph_valid && verdict.take) begin
                push_data <= ph_data;
            end
        end
    end

    assign rsp = rsp_q;

endmodule

// File: rtl/bwr_chk.sv
module bwr_chk #(
    parameter int DW  = 32,
    parameter int FFW = 6,
    parameter int QW  = 2
) (
    input logic           clk,
    input logic           rst,
    input logic           ph_valid,
    input logic           ph_first,
    input logic           ph_fbb,
    input logic [1:0]     ph_kind,
    input logic           ph_up,
    input logic [DW-1:0]  ph_data,
    input logic           cfg_fbb_cmd,
    input logic           cfg_fbb_brctl,
    input logic [FFW-1:0] fifo_free,
    input logic [QW-1:0]  dtq_free,
    input logic [1:0]     rsp,
    input logic           push_vld,
    input logic [DW-1:0]  push_data
);
    logic fbb_ok;
    assign fbb_ok = !(ph_first && ph_fbb) || (ph_up ? cfg_fbb_cmd : cfg_fbb_brctl);

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (rsp == 2'b00 && !push_vld)); // R1

    AST_DLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && ph_kind == 2'b00 && dtq_free != '0 && fbb_ok) |=> (rsp == 2'b11 && push_vld)); // R2

    AST_DLY_NO_ENTRY: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && ph_kind == 2'b00 && dtq_free == '0) |=> (rsp == 2'b10 && !push_vld)); // R3

    AST_FIFO_EMPTY_ROOM: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && (ph_kind == 2'b01 || ph_kind == 2'b10) && fifo_free == '0) |=> (rsp == 2'b10 && !push_vld)); // R4

    AST_FIFO_LAST_WORD: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && (ph_kind == 2'b01 || ph_kind == 2'b10) && fifo_free == FFW'(1) && fbb_ok) |=> (rsp == 2'b11)); // R5

    AST_FBB_REFUSED: assert property (@(posedge clk) disable iff (rst)
        (ph_valid && !fbb_ok) |=> (rsp == 2'b10 && !push_vld)); // R10

    AST_PUSH_WORD: assert property (@(posedge clk) disable iff (rst)
        push_vld |-> (push_data == $past(ph_data))); // R11

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !ph_valid |=> (rsp == 2'b00 && !push_vld)); // R12

endmodule

bind bwr_term bwr_chk #(.DW(DW), .FFW(FFW), .QW(QW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .ph_valid      (ph_valid),
    .ph_first      (ph_first),
    .ph_fbb        (ph_fbb),
    .ph_kind       (ph_kind),
    .ph_up         (ph_up),
    .ph_data       (ph_data),
    .cfg_fbb_cmd   (cfg_fbb_cmd),
    .cfg_fbb_brctl (cfg_fbb_brctl),
    .fifo_free     (fifo_free),
    .dtq_free      (dtq_free),
    .rsp           (rsp),
    .push_vld      (push_vld),
    .push_data     (push_data)
);

// File: tb/bwr_term_tb_top.sv
module bwr_term_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        ph_valid, ph_first, ph_fbb, ph_up;
    logic [1:0]  ph_kind;
    logic [29:0] ph_addr;
    logic [31:0] ph_data;
    logic [7:0]  cfg_cls;
    logic        cfg_disc_cl, cfg_fbb_cmd, cfg_fbb_brctl;
    logic [5:0]  fifo_free;
    logic [1:0]  dtq_free;
    logic [1:0]  rsp;
    logic        push_vld;
    logic [31:0] push_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    bwr_term dut_i (
        .clk(clk), .rst(rst), .ph_valid(ph_valid), .ph_first(ph_first), .ph_fbb(ph_fbb),
        .ph_kind(ph_kind), .ph_up(ph_up), .ph_addr(ph_addr), .ph_data(ph_data),
        .cfg_cls(cfg_cls), .cfg_disc_cl(cfg_disc_cl), .cfg_fbb_cmd(cfg_fbb_cmd),
        .cfg_fbb_brctl(cfg_fbb_brctl), .fifo_free(fifo_free), .dtq_free(dtq_free),
        .rsp(rsp), .push_vld(push_vld), .push_data(push_data)
    );

    function automatic bit cls_legal(input logic [7:0] c);
        return c == 8'd1 || c == 8'd2 || c == 8'd4 || c == 8'd8 || c == 8'd16;
    endfunction

    // Expected answer and the requirement that decides it.
    function automatic logic [1:0] expect_rsp(output string tag);
        logic [29:0] nxt;
        bit page, line, brk;
        if (ph_kind == 2'b11) begin tag = "R3"; return 2'b10; end
        if (ph_first && ph_fbb && !(ph_up ? cfg_fbb_cmd : cfg_fbb_brctl)) begin
            tag = "R10"; return 2'b10;
        end
        if (ph_kind == 2'b00) begin
            if (dtq_free == 2'd0) begin tag = "R3"; return 2'b10; end
            tag = "R2"; return 2'b11;
        end
        if (fifo_free == 6'd0) begin tag = "R4"; return 2'b10; end
        if (fifo_free == 6'd1) begin tag = "R5"; return 2'b11; end
        nxt  = ph_addr + 30'd1;
        page = (nxt % 30'd1024) == 30'd0;
        line = cls_legal(cfg_cls) && ((nxt % {22'd0, cfg_cls}) == 30'd0);
        if (ph_kind == 2'b01) begin
            if (cfg_disc_cl && cls_legal(cfg_cls)) begin tag = "R7"; brk = line; end
            else if (cfg_disc_cl) begin tag = "R8"; brk = page; end
            else begin tag = "R6"; brk = page; end
        end else begin
            tag = "R9";
            brk = page || (line && ({2'd0, fifo_free} - 8'd1 < cfg_cls));
        end
        return brk ? 2'b11 : 2'b01;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp,
                         input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive a phase on a falling edge, read the registered answer one full cycle later.
    task automatic phase(input logic [1:0] k, input logic [29:0] a, input logic [5:0] ff,
                         input logic [1:0] dq, input logic fst, input logic fb);
        string tag;
        logic [1:0] e;
        logic [31:0] d;
        d = $urandom;
        ph_valid = 1'b1; ph_kind = k; ph_addr = a; fifo_free = ff; dtq_free = dq;
        ph_first = fst; ph_fbb = fb; ph_data = d;
        e = expect_rsp(tag);
        @(negedge clk);
        check(tag, {30'd0, rsp}, {30'd0, e}, "rsp");
        check(tag, {31'd0, push_vld}, {31'd0, e[0]}, "push_vld");
        if (e[0]) check("R11", push_data, d, "push_data");
    endtask

    task automatic idle_cycle();
        ph_valid = 1'b0; ph_data = $urandom;
        @(negedge clk);
        check("R12", {30'd0, rsp}, 32'd0, "idle rsp");
        check("R12", {31'd0, push_vld}, 32'd0, "idle push");
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst = 1'b1; ph_valid = 1'b0; ph_first = 1'b0; ph_fbb = 1'b0; ph_kind = 2'b00;
        ph_up = 1'b0; ph_addr = '0; ph_data = '0; cfg_cls = 8'd8; cfg_disc_cl = 1'b0;
        cfg_fbb_cmd = 1'b1; cfg_fbb_brctl = 1'b1; fifo_free = 6'd40; dtq_free = 2'd2;
        repeat (3) @(negedge clk);
        check("R1", {30'd0, rsp}, 32'd0, "reset rsp");
        check("R1", {31'd0, push_vld}, 32'd0, "reset push");
        rst = 1'b0;
        @(negedge clk);
        check("R1", {30'd0, rsp}, 32'd0, "post-reset rsp");

        // R2 / R3: delayed writes
        phase(2'b00, 30'h100, 6'd40, 2'd1, 1'b1, 1'b0);
        phase(2'b00, 30'h100, 6'd40, 2'd0, 1'b1, 1'b0);
        phase(2'b11, 30'h100, 6'd40, 2'd3, 1'b1, 1'b0);
        // R4 / R5: FIFO room
        phase(2'b01, 30'h200, 6'd0, 2'd1, 1'b1, 1'b0);
        phase(2'b10, 30'h200, 6'd1, 2'd1, 1'b0, 1'b0);
        // R6: page boundary in page mode
        phase(2'b01, 30'h3fe, 6'd40, 2'd1, 1'b0, 1'b0);
        phase(2'b01, 30'h3ff, 6'd40, 2'd1, 1'b0, 1'b0);
        phase(2'b01, 30'h407, 6'd40, 2'd1, 1'b0, 1'b0);
        // R7: line mode, line of 8
        cfg_disc_cl = 1'b1;
        phase(2'b01, 30'h407, 6'd40, 2'd1, 1'b0, 1'b0);
        phase(2'b01, 30'h406, 6'd40, 2'd1, 1'b0, 1'b0);
        // R8: invalid line size falls back to page
        cfg_cls = 8'd6;
        phase(2'b01, 30'h407, 6'd40, 2'd1, 1'b0, 1'b0);
        phase(2'b01, 30'h7ff, 6'd40, 2'd1, 1'b0, 1'b0);
        // R9: invalidate writes
        cfg_cls = 8'd16; cfg_disc_cl = 1'b0;
        phase(2'b10, 30'h40f, 6'd40, 2'd1, 1'b0, 1'b0);
        phase(2'b10, 30'h40f, 6'd16, 2'd1, 1'b0, 1'b0);
        phase(2'b10, 30'h40f, 6'd17, 2'd1, 1'b0, 1'b0);
        phase(2'b10, 30'hbff, 6'd40, 2'd1, 1'b0, 1'b0);
        // R10: fast back-to-back enables by direction
        cfg_fbb_cmd = 1'b0; cfg_fbb_brctl = 1'b1;
        ph_up = 1'b1; phase(2'b01, 30'h10, 6'd40, 2'd1, 1'b1, 1'b1);
        ph_up = 1'b0; phase(2'b01, 30'h10, 6'd40, 2'd1, 1'b1, 1'b1);
        cfg_fbb_cmd = 1'b1; cfg_fbb_brctl = 1'b0;
        phase(2'b00, 30'h10, 6'd40, 2'd1, 1'b1, 1'b1);
        ph_up = 1'b1; phase(2'b00, 30'h10, 6'd40, 2'd1, 1'b1, 1'b1);
        // R12
        idle_cycle();

        for (int i = 0; i < 600; i++) begin
            logic [29:0] a;
            logic [5:0]  ff;
            int pick;
            a = 30'($urandom);
            if ($urandom_range(0, 2) == 0) a[9:0] = 10'h3ff - 10'($urandom_range(0, 20));
            ff = ($urandom_range(0, 3) == 0) ? 6'($urandom_range(0, 3)) : 6'($urandom_range(0, 63));
            pick = $urandom_range(0, 7);
            cfg_cls = (pick < 5) ? 8'(1 << pick) : 8'($urandom_range(0, 32));
            cfg_disc_cl = 1'($urandom);
            cfg_fbb_cmd = 1'($urandom); cfg_fbb_brctl = 1'($urandom);
            ph_up = 1'($urandom);
            if ($urandom_range(0, 9) == 0) idle_cycle();
            phase(2'($urandom), a, ff, 2'($urandom), 1'($urandom), 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule